// File: doc/BRIEF.md
# Four-Slot Instruction Decode Steering

This block sits between an instruction window buffer and a bank of four instruction decoders. Each cycle it looks at a window of pre-decoded descriptors. The descriptors are already aligned to instruction boundaries, and each one carries a valid bit, a uop count, a byte offset within its 16-byte fetch block, a branch flag and a predicted-taken flag. The block places the descriptors, in program order, into decoder slots.

The slots are asymmetric. Slot 0 can take an instruction of up to four uops. Slots 1 to 3 take only single-uop instructions. A decode group closes at any of these points:
- a multi-uop instruction that cannot reach slot 0 in the current group;
- after a complex instruction;
- at the edge of the fetch block;
- after a branch predicted taken;
- at the first empty window entry.

The number of descriptors consumed goes back to the window buffer combinationally, in the same cycle. When a fetch has just been redirected to a target that is not 16-byte aligned, the descriptors below the target offset are consumed without being steered.

An instruction of more than four uops is a microcode flow. It goes to slot 0 alone, with a marker. Steering then stops until the sequencer acknowledges. Steering also stops while the downstream ready is low.

Top module: `decslot_steer`

## Requirements
- R1: After reset, the microcode wait flag `seq_busy` is 0.
- R2: Valid single-uop descriptors are placed in order into slots 0, 1, 2, 3. The slots are filled contiguously from slot 0. `take_cnt` equals the number consumed, at most 4 in one group.
- R3: Slots 1 to 3 only receive descriptors whose uop count (3-bit field) is 1. A descriptor with a count of 2 or more that is not first in the group ends the group before it, and it is not consumed. A 2-uop descriptor in slot 0 does not end the group.
- R4: A complex descriptor (uop count 3 or 4) is placed only in slot 0, and nothing follows it in that cycle.
- R5: Entry i (i > 0) whose 4-bit byte offset is less than or equal to the offset of entry i-1 starts a new fetch block. If it is not first in the group, the group ends before it.
- R6: A descriptor with both its branch flag and its predicted-taken flag set ends the group after itself. A branch without the predicted-taken flag, or the predicted-taken flag without the branch flag, does not end the group.
- R7: While `redir_vld` is high, the leading descriptors whose offset is below `redir_off` are counted in `take_cnt` but placed in no slot. Steering starts at the first descriptor at or above the target offset, or at the start of a new fetch block.
- R8: A descriptor with a uop count of 5 or more goes to slot 0 alone, with `slot_ucode` = 1. This happens only when it is first in the group; otherwise the group ends before it. From the next cycle, `seq_busy` is 1 and nothing is steered (`take_cnt` = 0) until a cycle with `seq_ack` high. After that cycle, `seq_busy` returns to 0.
- R9: While `dn_rdy` is low, no slot is valid, `take_cnt` is 0, and a microcode descriptor does not set `seq_busy`.
- R10: An entry with its valid bit low ends the group. It and all later entries are ignored that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ent_vld | input | WIN | Per-entry valid bit |
| ent_uops | input | WIN x 3 | Per-entry uop count |
| ent_off | input | WIN x 4 | Per-entry byte offset within the fetch block |
| ent_br | input | WIN | Per-entry branch flag |
| ent_tk | input | WIN | Per-entry predicted-taken flag |
| redir_vld | input | 1 | Window starts at a redirect target this cycle |
| redir_off | input | 4 | Byte offset of the redirect target |
| dn_rdy | input | 1 | Decoders can accept a group |
| seq_ack | input | 1 | Microcode sequencer acknowledge |
| slot_vld | output | 4 | Per-slot valid |
| slot_sel | output | 4 x log2(WIN) | Window entry index placed in each slot |
| slot_ucode | output | 1 | Slot 0 carries a microcode flow |
| take_cnt | output | log2(WIN+1) | Descriptors consumed this cycle |
| seq_busy | output | 1 | Waiting for the sequencer acknowledge |

## Verification
Several group-closing causes can apply in the same cycle. The sharpest pairing is a redirect skip together with a predicted-taken branch. The bench presents a window in which entries below the target are dropped and the first steered entry is itself a taken branch. It then checks three things: the skipped entries are counted in `take_cnt`, exactly slot 0 is valid, and slot 0 points past the skipped prefix. A second overlap is a microcode flow arriving while `dn_rdy` is low. Here the bench checks both that nothing is steered and that `seq_busy` stays 0 after the clock edge.

// File: rtl/decslot_pkg.sv
// Shared defaults and types for the decode slot steering block.
package decslot_pkg;
    localparam int WIN_DEF   = 8;   // window entries presented per cycle
    localparam int NSLOT_DEF = 4;   // decoder slots
    localparam int UW_DEF    = 3;   // uop count field width
    localparam int OW_DEF    = 4;   // byte offset width (16-byte block)
    localparam int S0MAX_DEF = 4;   // largest uop count slot 0 decodes
    localparam int SMAX_DEF  = 1;   // largest uop count slots 1..N-1 decode
    localparam int CPLX_DEF  = 2;   // uop counts above this end the group

    typedef enum logic {
        HOLD_FREE = 1'b0,
        HOLD_WAIT = 1'b1
    } hold_e;
endpackage

// File: rtl/decslot_class.sv
// Per-entry classifier: derives steering attributes from one descriptor.
// Assumes the offset of the previous entry is supplied (zero for entry 0,
// where has_prev is 0).
module decslot_class #(
    parameter int UW    = decslot_pkg::UW_DEF,
    parameter int OW    = decslot_pkg::OW_DEF,
    parameter int S0MAX = decslot_pkg::S0MAX_DEF,
    parameter int SMAX  = decslot_pkg::SMAX_DEF,
    parameter int CPLX  = decslot_pkg::CPLX_DEF
) (
    input  logic          has_prev,
    input  logic [UW-1:0] uops,
    input  logic [OW-1:0] off,
    input  logic [OW-1:0] prev_off,
    input  logic          br,
    input  logic          tk,
    input  logic          redir,
    input  logic [OW-1:0] tgt_off,
    output logic          need0,
    output logic          ends,
    output logic          ucode,
    output logic          wrap,
    output logic          below
);
    // Attribute decode for a single descriptor.
    always_comb begin
        need0 = (uops > UW'(SMAX));
        ucode = (uops > UW'(S0MAX));
        ends  = (uops > UW'(CPLX)) || (br && tk);
        wrap  = has_prev && (off <= prev_off);
        below = redir && (off < tgt_off);
    end
endmodule

// File: rtl/decslot_scan.sv
// Ordered scan: walks the window once and assigns entries to slots.
// Assumes go is low whenever steering must be suppressed.
module decslot_scan #(
    parameter int WIN   = decslot_pkg::WIN_DEF,
    parameter int NSLOT = decslot_pkg::NSLOT_DEF,
    parameter int IW    = $clog2(WIN),
    parameter int CW    = $clog2(WIN + 1)
) (
    input  logic                   go,
    input  logic [WIN-1:0]         vld,
    input  logic [WIN-1:0]         need0,
    input  logic [WIN-1:0]         ends,
    input  logic [WIN-1:0]         ucode,
    input  logic [WIN-1:0]         wrap,
    input  logic [WIN-1:0]         below,
    output logic [NSLOT-1:0]       slot_vld,
    output logic [NSLOT-1:0][IW-1:0] slot_sel,
    output logic                   slot_ucode,
    output logic [CW-1:0]          take
);
    localparam int SLW = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam int NXW = SLW + 1;

    // Linear walk: skip redirect prefix, fill slots, stop at a group break.
    always_comb begin
        logic           stop;
        logic           skipping;
        logic [NXW-1:0] nxt;
        slot_vld   = '0;
        slot_sel   = '0;
        slot_ucode = 1'b0;
        take       = '0;
        stop       = !go;
        skipping   = 1'b1;
        nxt        = '0;
        for (int i = 0; i < WIN; i++) begin
            if (!stop) begin
                if (!vld[i]) begin
                    stop = 1'b1;
                end else if (skipping && below[i] && !wrap[i]) begin
                    take = take + CW'(1);
                end else begin
                    skipping = 1'b0;
                    if ((nxt != '0) && (wrap[i] || need0[i])) begin
                        stop = 1'b1;
                    end else begin
                        slot_vld[nxt[SLW-1:0]] = 1'b1;
                        slot_sel[nxt[SLW-1:0]] = IW'(i);
                        take = take + CW'(1);
                        if (ucode[i]) slot_ucode = 1'b1;
                        if (ends[i] || ucode[i] || (nxt == NXW'(NSLOT - 1)))
                            stop = 1'b1;
                        nxt = nxt + NXW'(1);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/decslot_hold.sv
// Microcode hold: after a microcode flow is steered, blocks steering
// until the sequencer acknowledges. Assumes issue only pulses when go was high.
module decslot_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic ack,
    output logic busy
);
    import decslot_pkg::*;

    hold_e state;

    // Wait-state register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                               state <= HOLD_FREE;
        else if (state == HOLD_WAIT && ack)       state <= HOLD_FREE;
        else if (state == HOLD_FREE && issue)     state <= HOLD_WAIT;
    end

    // Expose the wait state.
    always_comb busy = (state == HOLD_WAIT);
endmodule

// File: rtl/decslot_steer.sv
// Top: steers window descriptors into a 4-1-1-1 decoder slot bank.
// Assumes descriptors are boundary aligned and presented in program order;
// the consumed count is returned combinationally to the window buffer.
module decslot_steer #(
    parameter int WIN   = decslot_pkg::WIN_DEF,
    parameter int NSLOT = decslot_pkg::NSLOT_DEF,
    parameter int UW    = decslot_pkg::UW_DEF,
    parameter int OW    = decslot_pkg::OW_DEF,
    parameter int S0MAX = decslot_pkg::S0MAX_DEF,
    parameter int SMAX  = decslot_pkg::SMAX_DEF,
    parameter int CPLX  = decslot_pkg::CPLX_DEF,
    localparam int IW   = $clog2(WIN),
    localparam int CW   = $clog2(WIN + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [WIN-1:0]           ent_vld,
    input  logic [WIN-1:0][UW-1:0]   ent_uops,
    input  logic [WIN-1:0][OW-1:0]   ent_off,
    input  logic [WIN-1:0]           ent_br,
    input  logic [WIN-1:0]           ent_tk,
    input  logic                     redir_vld,
    input  logic [OW-1:0]            redir_off,
    input  logic                     dn_rdy,
    input  logic                     seq_ack,
    output logic [NSLOT-1:0]         slot_vld,
    output logic [NSLOT-1:0][IW-1:0] slot_sel,
    output logic                     slot_ucode,
    output logic [CW-1:0]            take_cnt,
    output logic                     seq_busy
);
    logic [WIN-1:0] need0, ends, ucode, wrap, below;
    logic           go;

    // Steering is allowed only with a ready downstream and no pending flow.
    always_comb go = dn_rdy && !seq_busy;

    for (genvar i = 0; i < WIN; i++) begin : g_cls
        localparam int PI = (i > 0) ? i - 1 : 0;
        decslot_class #(
            .UW(UW), .OW(OW), .S0MAX(S0MAX), .SMAX(SMAX), .CPLX(CPLX)
        ) u_cls (
            .has_prev (i > 0),
            .uops     (ent_uops[i]),
            .off      (ent_off[i]),
            .prev_off (ent_off[PI]),
            .br       (ent_br[i]),
            .tk       (ent_tk[i]),
            .redir    (redir_vld),
            .tgt_off  (redir_off),
            .need0    (need0[i]),
            .ends     (ends[i]),
            .ucode    (ucode[i]),
            .wrap     (wrap[i]),
            .below    (below[i])
        );
    end

    decslot_scan #(.WIN(WIN), .NSLOT(NSLOT), .IW(IW), .CW(CW)) u_scan (
        .go         (go),
        .vld        (ent_vld),
        .need0      (need0),
        .ends       (ends),
        .ucode      (ucode),
        .wrap       (wrap),
        .below      (below),
        .slot_vld   (slot_vld),
        .slot_sel   (slot_sel),
        .slot_ucode (slot_ucode),
        .take       (take_cnt)
    );

    decslot_hold u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .issue (slot_ucode),
        .ack   (seq_ack),
        .busy  (seq_busy)
    );
endmodule

// File: rtl/decslot_steer_chk.sv
// Checker for decslot_steer: temporal and cross-port properties.
module decslot_steer_chk #(
    parameter int WIN   = 8,
    parameter int NSLOT = 4,
    parameter int UW    = 3,
    parameter int IW    = 3,
    parameter int CW    = 4,
    parameter int SMAX  = 1,
    parameter int CPLX  = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [WIN-1:0][UW-1:0]   ent_uops,
    input logic                     dn_rdy,
    input logic                     seq_ack,
    input logic [NSLOT-1:0]         slot_vld,
    input logic [NSLOT-1:0][IW-1:0] slot_sel,
    input logic                     slot_ucode,
    input logic [CW-1:0]            take_cnt,
    input logic                     seq_busy
);
    AST_IDLE_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !dn_rdy |-> (slot_vld == '0 && take_cnt == '0)); // R9
    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |-> (slot_vld == '0 && take_cnt == '0)); // R8
    AST_UCODE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        slot_ucode |-> (slot_vld == NSLOT'(1))); // R8
    AST_BUSY_AFTER_UCODE: assert property (@(posedge clk) disable iff (!rst_n)
        slot_ucode |=> seq_busy); // R8
    AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_busy && seq_ack) |=> !seq_busy); // R8
    AST_SLOTS_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_vld & (slot_vld + NSLOT'(1))) == '0)); // R2
    AST_TAKE_COVERS_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(take_cnt) >= $countones(slot_vld))); // R7
    AST_COMPLEX_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_vld[0] && ent_uops[slot_sel[0]] > UW'(CPLX)) |-> (slot_vld[NSLOT-1:1] == '0)); // R4

    for (genvar k = 1; k < NSLOT; k++) begin : g_single
        AST_SLOT_SINGLE_UOP: assert property (@(posedge clk) disable iff (!rst_n)
            slot_vld[k] |-> (ent_uops[slot_sel[k]] <= UW'(SMAX))); // R3
    end
endmodule

bind decslot_steer decslot_steer_chk #(
    .WIN(WIN), .NSLOT(NSLOT), .UW(UW), .IW(IW), .CW(CW), .SMAX(SMAX), .CPLX(CPLX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ent_uops   (ent_uops),
    .dn_rdy     (dn_rdy),
    .seq_ack    (seq_ack),
    .slot_vld   (slot_vld),
    .slot_sel   (slot_sel),
    .slot_ucode (slot_ucode),
    .take_cnt   (take_cnt),
    .seq_busy   (seq_busy)
);

// File: tb/test_decslot_steer.sv
// Directed bench for decslot_steer: one task per scenario.
module test_decslot_steer;
    localparam int CLK_PERIOD = 10;
    localparam int WIN = 8;
    localparam int NSLOT = 4;
    localparam int IW = 3;
    localparam int CW = 4;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [WIN-1:0]         ent_vld = '0;
    logic [WIN-1:0][2:0]    ent_uops = '0;
    logic [WIN-1:0][3:0]    ent_off = '0;
    logic [WIN-1:0]         ent_br = '0;
    logic [WIN-1:0]         ent_tk = '0;
    logic                   redir_vld = 1'b0;
    logic [3:0]             redir_off = '0;
    logic                   dn_rdy = 1'b1;
    logic                   seq_ack = 1'b0;
    logic [NSLOT-1:0]       slot_vld;
    logic [NSLOT-1:0][IW-1:0] slot_sel;
    logic                   slot_ucode;
    logic [CW-1:0]          take_cnt;
    logic                   seq_busy;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;

    decslot_steer i_decslot_steer (
        .clk(clk), .rst_n(rst_n), .ent_vld(ent_vld), .ent_uops(ent_uops),
        .ent_off(ent_off), .ent_br(ent_br), .ent_tk(ent_tk),
        .redir_vld(redir_vld), .redir_off(redir_off), .dn_rdy(dn_rdy),
        .seq_ack(seq_ack), .slot_vld(slot_vld), .slot_sel(slot_sel),
        .slot_ucode(slot_ucode), .take_cnt(take_cnt), .seq_busy(seq_busy)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic clr();
        ent_vld = '0; ent_uops = '0; ent_off = '0; ent_br = '0; ent_tk = '0;
        redir_vld = 1'b0; redir_off = '0;
    endtask

    task automatic put(int i, int u, int o, bit br, bit tk);
        ent_vld[i] = 1'b1; ent_uops[i] = 3'(u); ent_off[i] = 4'(o);
        ent_br[i] = br; ent_tk[i] = tk;
    endtask

    task automatic chk(string tag, logic [3:0] ev, int et, int s0, int s1, int s2, int s3, logic eu);
        int es[4];
        bit bad;
        es = '{s0, s1, s2, s3};
        bad = (slot_vld !== ev) || (int'(take_cnt) != et) || (slot_ucode !== eu);
        for (int k = 0; k < NSLOT; k++)
            if (ev[k] && int'(slot_sel[k]) != es[k]) bad = 1'b1;
        n_vec++;
        if (bad) begin
            n_bad++;
            $display("FAIL %s: vld=%b take=%0d ucode=%b sel=%0d,%0d,%0d,%0d expected vld=%b take=%0d ucode=%b sel=%0d,%0d,%0d,%0d",
                     tag, slot_vld, take_cnt, slot_ucode, slot_sel[0], slot_sel[1],
                     slot_sel[2], slot_sel[3], ev, et, eu, s0, s1, s2, s3);
        end
    endtask

    task automatic chkb(string tag, logic eb);
        n_vec++;
        if (seq_busy !== eb) begin
            n_bad++;
            $display("FAIL %s: seq_busy=%b expected %b", tag, seq_busy, eb);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; clr(); #1;
        chkb("R1 reset", 1'b0);
        chk("R10 empty window", 4'b0000, 0, 0, 0, 0, 0, 1'b0);
        @(negedge clk); clr(); put(0, 1, 0, 0, 0); put(2, 1, 4, 0, 0); #1;
        chk("R10 hole ends group", 4'b0001, 1, 0, 0, 0, 0, 1'b0);
    endtask

    task automatic t_fill();
        @(negedge clk); clr();
        for (int i = 0; i < 6; i++) put(i, 1, 2 * i, 0, 0);
        #1 chk("R2 four simple", 4'b1111, 4, 0, 1, 2, 3, 1'b0);
        @(negedge clk); clr(); put(0, 1, 0, 0, 0); put(1, 1, 3, 0, 0); #1;
        chk("R2 two simple", 4'b0011, 2, 0, 1, 0, 0, 1'b0);
    endtask

    task automatic t_realign();
        @(negedge clk); clr(); put(0, 1, 0, 0, 0); put(1, 2, 2, 0, 0); put(2, 1, 5, 0, 0); #1;
        chk("R3 two-uop stops group", 4'b0001, 1, 0, 0, 0, 0, 1'b0);
        @(negedge clk); clr(); put(0, 2, 0, 0, 0);
        for (int i = 1; i < 5; i++) put(i, 1, 1 + 2 * i, 0, 0);
        #1 chk("R3 two-uop in slot 0 continues", 4'b1111, 4, 0, 1, 2, 3, 1'b0);
    endtask

    task automatic t_complex();
        @(negedge clk); clr(); put(0, 3, 0, 0, 0); put(1, 1, 4, 0, 0); #1;
        chk("R4 complex closes group", 4'b0001, 1, 0, 0, 0, 0, 1'b0);
        @(negedge clk); clr(); put(0, 1, 0, 0, 0); put(1, 1, 2, 0, 0); put(2, 4, 4, 0, 0); put(3, 1, 9, 0, 0); #1;
        chk("R4 complex not first", 4'b0011, 2, 0, 1, 0, 0, 1'b0);
        @(negedge clk); clr(); put(0, 4, 0, 0, 0); put(1, 1, 5, 0, 0); #1;
        chk("R4 four-uop in slot 0", 4'b0001, 1, 0, 0, 0, 0, 1'b0);
    endtask

    task automatic t_window();
        @(negedge clk); clr(); put(0, 1, 0, 0, 0); put(1, 1, 5, 0, 0); put(2, 1, 12, 0, 0);
        put(3, 1, 1, 0, 0); put(4, 1, 3, 0, 0); #1;
        chk("R5 block edge", 4'b0111, 3, 0, 1, 2, 0, 1'b0);
        @(negedge clk); clr(); put(0, 1, 0, 0, 0); put(1, 1, 4, 0, 0); put(2, 1, 4, 0, 0); #1;
        chk("R5 equal offset", 4'b0011, 2, 0, 1, 0, 0, 1'b0);
    endtask

    task automatic t_branch();
        @(negedge clk); clr(); put(0, 1, 0, 0, 0); put(1, 1, 2, 1, 1); put(2, 1, 4, 0, 0); put(3, 1, 6, 0, 0); #1;
        chk("R6 taken branch", 4'b0011, 2, 0, 1, 0, 0, 1'b0);
        @(negedge clk); ent_tk[1] = 1'b0; #1;
        chk("R6 not-taken branch", 4'b1111, 4, 0, 1, 2, 3, 1'b0);
        @(negedge clk); ent_br[1] = 1'b0; ent_tk[1] = 1'b1; #1;
        chk("R6 taken flag without branch", 4'b1111, 4, 0, 1, 2, 3, 1'b0);
    endtask

    task automatic t_redirect();
        @(negedge clk); clr(); redir_vld = 1'b1; redir_off = 4'd6;
        put(0, 1, 0, 0, 0); put(1, 1, 3, 0, 0); put(2, 1, 6, 0, 0);
        put(3, 1, 9, 0, 0); put(4, 1, 11, 0, 0); put(5, 1, 13, 0, 0); #1;
        chk("R7 skip prefix", 4'b1111, 6, 2, 3, 4, 5, 1'b0);
        @(negedge clk); clr(); redir_vld = 1'b1; redir_off = 4'd10;
        put(0, 1, 0, 0, 0); put(1, 1, 4, 0, 0); put(2, 1, 12, 0, 0); #1;
        chk("R7 skip then one", 4'b0001, 3, 2, 0, 0, 0, 1'b0);
        @(negedge clk); clr(); redir_vld = 1'b1; redir_off = 4'd6;
        put(0, 1, 0, 0, 0); put(1, 1, 6, 1, 1); put(2, 1, 8, 0, 0); #1;
        chk("R7 R6 skip with taken branch", 4'b0001, 2, 1, 0, 0, 0, 1'b0);
    endtask

    task automatic t_ready();
        @(negedge clk); clr(); dn_rdy = 1'b0; put(0, 6, 0, 0, 0); put(1, 1, 2, 0, 0); #1;
        chk("R9 not ready", 4'b0000, 0, 0, 0, 0, 0, 1'b0);
        @(negedge clk); #1;
        chkb("R9 ucode ignored when not ready", 1'b0);
        dn_rdy = 1'b1; clr();
    endtask

    task automatic t_ucode();
        @(negedge clk); clr(); put(0, 1, 0, 0, 0); put(1, 6, 2, 0, 0); #1;
        chk("R8 ucode not first", 4'b0001, 1, 0, 0, 0, 0, 1'b0);
        @(negedge clk); clr(); put(0, 6, 0, 0, 0); put(1, 1, 2, 0, 0); #1;
        chk("R8 ucode alone", 4'b0001, 1, 0, 0, 0, 0, 1'b1);
        @(negedge clk); #1;
        chkb("R8 busy after flow", 1'b1);
        clr(); put(0, 1, 0, 0, 0); put(1, 1, 4, 0, 0); #1;
        chk("R8 held while busy", 4'b0000, 0, 0, 0, 0, 0, 1'b0);
        @(negedge clk); #1;
        chkb("R8 still busy", 1'b1);
        seq_ack = 1'b1;
        @(negedge clk); seq_ack = 1'b0; #1;
        chkb("R8 released", 1'b0);
        chk("R8 steering resumes", 4'b0011, 2, 0, 1, 0, 0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_fill();
        t_realign();
        t_complex();
        t_window();
        t_branch();
        t_redirect();
        t_ready();
        t_ucode();
        @(negedge clk); clr();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule